// File: doc/BRIEF.md
# Debug Show-Cycle Bus Monitor

This block mirrors the activity of an on-chip processor bus onto the external bus pins so that an emulator or logic analyser can follow what the core is doing. For every internal transfer it presents the address, the transfer kind, the transfer size and the direction on the external pins. If data display is switched on, it also puts the transferred data word on the external data bus. The word appears one clock after the internal transfer ends. The output-enable and byte-enable strobes stay negated, so no external memory responds, and an observer can tell these mirrored cycles apart from real external accesses.

Data display is always on when the emulation strap is high. In normal (master) mode it is off after reset, and software turns it on or off through a single-bit configuration write. Alongside the mirrored cycle, the block drives a 2-bit region code that sorts each access by address range. The emulator uses this code to tell which memory the core is touching.

Top module: `show_cycle_mon`

## Requirements
- R1: While `ib_valid` is high, `ext_addr`, `ext_kind`, `ext_size` and `ext_rd` (1 = read, the inverse of `ib_write`) follow the internal bus in the same cycle, whether data display is on or off.
- R2: When data display is off, `ext_d_oe` stays 0, which means the data bus is released (high impedance).
- R3: When data display is on, a clock edge with `ib_valid` and `ib_done` both high sets `ext_d_oe` to 1 and loads the captured word onto `ext_d_o` for the following cycle. A cycle without `ib_done` (a wait state) captures nothing.
- R4: The captured word is `ib_wdata` for a write (`ib_write` = 1) and `ib_rdata` for a read.
- R5: `ext_d_oe` stays high for exactly one cycle after a termination edge and falls at the next edge unless that edge is also a termination.
- R6: With `emu_mode` = 1, data display is on whatever the configuration bit holds.
- R7: With `emu_mode` = 0, data display is off after reset. A clock edge with `cfg_we` = 1 loads `cfg_show_en` into the enable bit (1 = on, 0 = off).
- R8: During a valid cycle, `ext_region` is 2'b11 for addresses 0x00C1_0000 to 0x00FF_FFFF, 2'b10 for 0x00C0_0000 to 0x00C0_FFFF, 2'b00 for 0x8000_0000 and above, and 2'b01 for every other address.
- R9: While `rst_n` is low, `ext_region` is 2'b11.
- R10: `ext_oe_n` is 1 and `ext_be_n` is 4'hF at all times.
- R11: When transfers terminate on back-to-back edges, each mirrored word appears in its own cycle, in order, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| emu_mode | input | 1 | Emulation strap; 1 forces data display on |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_show_en | input | 1 | Enable value loaded on `cfg_we` |
| ib_valid | input | 1 | Internal transfer in progress |
| ib_done | input | 1 | Internal transfer terminates this cycle |
| ib_addr | input | 32 | Internal address |
| ib_write | input | 1 | 1 = write, 0 = read |
| ib_kind | input | 3 | Transfer kind code |
| ib_size | input | 2 | Transfer size code |
| ib_wdata | input | 32 | Processor write data |
| ib_rdata | input | 32 | Slave read data |
| ext_addr | output | 32 | Mirrored address |
| ext_kind | output | 3 | Mirrored transfer kind |
| ext_size | output | 2 | Mirrored transfer size |
| ext_rd | output | 1 | Mirrored direction, 1 = read |
| ext_region | output | 2 | Region code for emulation |
| ext_oe_n | output | 1 | Output enable, held negated |
| ext_be_n | output | 4 | Byte enables, held negated |
| ext_d_o | output | 32 | External data value |
| ext_d_oe | output | 1 | External data drive enable |

## Verification
The data phase of one transfer can fall in the same cycle as the address phase of the next. In that cycle, `ext_d_o` carries the word captured at the previous edge while `ext_addr`, `ext_rd` and `ext_region` already describe the new transfer. The bench provokes this by issuing transfers that terminate on consecutive edges. In the overlap cycle it checks that the data is the earlier word and that the address and direction belong to the later transfer. At the next edge it checks that the later word replaces the earlier one with `ext_d_oe` still high.

// File: rtl/show_cycle_mon.sv
module show_cycle_mon #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int KIND_W = 3,
  parameter int SIZE_W = 2,
  parameter logic [ADDR_W-1:0] REG_LO  = 32'h00C1_0000,
  parameter logic [ADDR_W-1:0] REG_HI  = 32'h00FF_FFFF,
  parameter logic [ADDR_W-1:0] PORT_LO = 32'h00C0_0000,
  parameter logic [ADDR_W-1:0] PORT_HI = 32'h00C0_FFFF,
  parameter logic [ADDR_W-1:0] EXT_LO  = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emu_mode,
  input  logic              cfg_we,
  input  logic              cfg_show_en,
  input  logic              ib_valid,
  input  logic              ib_done,
  input  logic [ADDR_W-1:0] ib_addr,
  input  logic              ib_write,
  input  logic [KIND_W-1:0] ib_kind,
  input  logic [SIZE_W-1:0] ib_size,
  input  logic [DATA_W-1:0] ib_wdata,
  input  logic [DATA_W-1:0] ib_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [KIND_W-1:0] ext_kind,
  output logic [SIZE_W-1:0] ext_size,
  output logic              ext_rd,
  output logic [1:0]        ext_region,
  output logic              ext_oe_n,
  output logic [DATA_W/8-1:0] ext_be_n,
  output logic [DATA_W-1:0] ext_d_o,
  output logic              ext_d_oe
);
  localparam int BE_W = DATA_W / 8;

  logic              shen_q;
  logic              show_on;
  logic              capture;
  logic [ADDR_W-1:0] addr_q;
  logic [KIND_W-1:0] kind_q;
  logic [SIZE_W-1:0] size_q;
  logic              rd_q;
  logic [1:0]        region_dec;

  assign show_on = emu_mode | shen_q;
  assign capture = show_on & ib_valid & ib_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      shen_q <= 1'b0;
    else if (cfg_we) shen_q <= cfg_show_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      kind_q <= '0;
      size_q <= '0;
      rd_q   <= 1'b1;
    end else if (ib_valid) begin
      addr_q <= ib_addr;
      kind_q <= ib_kind;
      size_q <= ib_size;
      rd_q   <= ~ib_write;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_d_oe <= 1'b0;
      ext_d_o  <= '0;
    end else begin
      ext_d_oe <= capture;
      if (capture) ext_d_o <= ib_write ? ib_wdata : ib_rdata;
    end

  assign ext_addr = ib_valid ? ib_addr  : addr_q;
  assign ext_kind = ib_valid ? ib_kind  : kind_q;
  assign ext_size = ib_valid ? ib_size  : size_q;
  assign ext_rd   = ib_valid ? ~ib_write : rd_q;

  always_comb begin
    if (ext_addr >= EXT_LO)                             region_dec = 2'b00;
    else if (ext_addr >= REG_LO && ext_addr <= REG_HI)   region_dec = 2'b11;
    else if (ext_addr >= PORT_LO && ext_addr <= PORT_HI) region_dec = 2'b10;
    else                                                 region_dec = 2'b01;
  end

  assign ext_region = rst_n ? region_dec : 2'b11;
  assign ext_oe_n   = 1'b1;
  assign ext_be_n   = {BE_W{1'b1}};
endmodule

module show_cycle_mon_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              emu_mode,
  input logic              ib_valid,
  input logic              ib_done,
  input logic              ib_write,
  input logic [ADDR_W-1:0] ib_addr,
  input logic [DATA_W-1:0] ib_wdata,
  input logic [1:0]        ext_region,
  input logic              ext_oe_n,
  input logic [DATA_W/8-1:0] ext_be_n,
  input logic [DATA_W-1:0] ext_d_o,
  input logic              ext_d_oe
);
  assert_strobes_negated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_oe_n && (&ext_be_n));

  assert_emu_forces_show_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && ib_valid && ib_done) |=> ext_d_oe);

  assert_write_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && ib_valid && ib_done && ib_write) |=> (ext_d_o == $past(ib_wdata)));

  assert_one_cycle_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ib_valid && ib_done) |=> !ext_d_oe);

  assert_external_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && ib_addr[ADDR_W-1]) |-> (ext_region == 2'b00));

  always_comb
    if (!rst_n) assert_reset_region_R9: assert (ext_region == 2'b11);
endmodule

bind show_cycle_mon show_cycle_mon_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .ib_valid(ib_valid),
  .ib_done(ib_done), .ib_write(ib_write), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
  .ext_region(ext_region), .ext_oe_n(ext_oe_n), .ext_be_n(ext_be_n),
  .ext_d_o(ext_d_o), .ext_d_oe(ext_d_oe)
);

// File: tb/show_cycle_mon_tb.sv
module show_cycle_mon_tb;
  logic clk = 0, rst_n = 0;
  logic emu_mode = 0, cfg_we = 0, cfg_show_en = 0;
  logic ib_valid = 0, ib_done = 0, ib_write = 0;
  logic [31:0] ib_addr = 0, ib_wdata = 0, ib_rdata = 0;
  logic [2:0] ib_kind = 0;
  logic [1:0] ib_size = 0;
  logic [31:0] ext_addr, ext_d_o;
  logic [2:0] ext_kind;
  logic [1:0] ext_size, ext_region;
  logic ext_rd, ext_oe_n, ext_d_oe;
  logic [3:0] ext_be_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  show_cycle_mon u_dut (.*);

  localparam int NV = 10;
  localparam logic [33:0] VEC [NV] = '{
    {32'h00C1_0000, 2'b11}, {32'h00FF_FFFF, 2'b11}, {32'h00C0_0000, 2'b10},
    {32'h00C0_FFFF, 2'b10}, {32'h00BF_FFFF, 2'b01}, {32'h0000_0000, 2'b01},
    {32'h0100_0000, 2'b01}, {32'h07FF_FFFF, 2'b01}, {32'h8000_0000, 2'b00},
    {32'hFFFF_FFFF, 2'b00}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic d, logic [31:0] a, logic w, logic [31:0] wd, logic [31:0] rd);
    @(negedge clk);
    ib_valid = v; ib_done = d; ib_addr = a; ib_write = w;
    ib_wdata = wd; ib_rdata = rd; ib_kind = a[2:0]; ib_size = a[5:4];
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic cfg(logic en);
    @(negedge clk); cfg_we = 1; cfg_show_en = en;
    @(negedge clk); cfg_we = 0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9, R10 in reset
    ib_valid = 1; ib_addr = 32'h8000_0000;
    #13;
    chk("R9 region in reset", ext_region, 2'b11);
    chk("R10 oe_n", ext_oe_n, 1);
    chk("R10 be_n", ext_be_n, 4'hF);
    chk("R7 no drive in reset", ext_d_oe, 0);
    ib_valid = 0;
    @(negedge clk); rst_n = 1;

    // R8 region table walk
    for (int i = 0; i < NV; i++) begin
      drive(1, 0, VEC[i][33:2], 0, 0, 0);
      chk("R8 region", ext_region, VEC[i][1:0]);
    end

    // R1, R2, R7: display off after reset in master mode
    drive(1, 1, 32'h0012_3435, 1, 32'hAAAA_0001, 32'h5555_0001);
    chk("R1 addr", ext_addr, 32'h0012_3435);
    chk("R1 kind", ext_kind, 3'd5);
    chk("R1 size", ext_size, 2'd3);
    chk("R1 rd", ext_rd, 0);
    idle();
    chk("R2 R7 data released when off", ext_d_oe, 0);

    // R7 enable, R3, R4 write
    cfg(1);
    drive(1, 1, 32'h00C0_0010, 1, 32'hCAFE_0001, 32'h1111_1111);
    chk("R1 rd write", ext_rd, 0);
    idle();
    chk("R3 drive", ext_d_oe, 1);
    chk("R4 write data", ext_d_o, 32'hCAFE_0001);
    idle();
    chk("R5 drop", ext_d_oe, 0);

    // R4 read
    drive(1, 1, 32'h9000_0000, 0, 32'h2222_2222, 32'hBEEF_0002);
    chk("R1 rd read", ext_rd, 1);
    idle();
    chk("R4 read data", ext_d_o, 32'hBEEF_0002);

    // R3 wait state captures nothing
    drive(1, 0, 32'h0000_0100, 1, 32'h3333_3333, 0);
    idle();
    chk("R3 wait no drive", ext_d_oe, 0);

    // R11 back-to-back with overlap
    drive(1, 1, 32'h00C1_0004, 1, 32'h0000_00A1, 0);
    drive(1, 1, 32'h8000_0008, 0, 0, 32'h0000_00B2);
    chk("R11 overlap data", ext_d_o, 32'h0000_00A1);
    chk("R11 overlap oe", ext_d_oe, 1);
    chk("R11 overlap addr", ext_addr, 32'h8000_0008);
    chk("R11 overlap rd", ext_rd, 1);
    chk("R11 overlap region", ext_region, 2'b00);
    idle();
    chk("R11 second data", ext_d_o, 32'h0000_00B2);
    chk("R11 second oe", ext_d_oe, 1);
    idle();
    chk("R5 drop after pair", ext_d_oe, 0);

    // R7 disable
    cfg(0);
    drive(1, 1, 32'h0000_0200, 1, 32'h4444_4444, 0);
    idle();
    chk("R7 disabled no drive", ext_d_oe, 0);

    // R6 emulation forces on
    emu_mode = 1;
    drive(1, 1, 32'h0000_0300, 1, 32'h5A5A_0006, 0);
    idle();
    chk("R6 emu drive", ext_d_oe, 1);
    chk("R6 emu data", ext_d_o, 32'h5A5A_0006);
    chk("R10 oe_n during show", ext_oe_n, 1);
    chk("R10 be_n during show", ext_be_n, 4'hF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule